// File: doc/BRIEF.md
# Prescaled 8-bit Event Timer

This block is an 8-bit up-counter that advances on ticks from one of two sources: the system instruction-cycle strobe, or rising transitions on an external count pin. The pin is brought into the clock domain through a two-flop synchronizer. A power-of-two prescaler with divisors from 2 to 256 can be placed between the chosen source and the counter, or taken out of the path so that every source tick advances the count. When the count wraps from 0xFF to 0x00, the block raises a sticky overflow flag and a one-cycle overflow pulse for an interrupt controller. The flag is set whether or not any interrupt is enabled downstream.

Software sets the counter to a start value so that the overflow falls after a chosen number of increments. Writing the counter also restarts the prescaler, so the first increment after a write always comes a full prescale period later. A control word written through a separate strobe selects the tick source, whether the prescaler is in the path, and the division ratio. The flag stays set until a clear strobe removes it.

All register accesses are single-cycle write strobes with their data. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Every strobe is accepted in the cycle it is high.

Top module: `tick_timer8`

## Requirements
- R1: After reset the count is 0x00, the flag and the pulse are low, and the control word is all zeros (instruction-cycle source, prescaler in path, ratio 2:1).
- R2: A count write loads the value at the next clock edge. It takes priority over an increment in the same cycle, so that cycle produces no wrap, no pulse and no flag change.
- R3: Control word decode: bit 5 selects the source (0 = instruction-cycle strobe, 1 = external pin) and bit 3 selects the prescaler (0 = in path, 1 = bypassed, one increment per source tick). Bits 7, 6 and 4 have no effect. A new control word applies from the next edge.
- R4: With the prescaler in the path, ratio bits 2:0 with value v give one increment per 2^(v+1) source ticks: 000 is 2:1 and 111 is 256:1.
- R5: A count write restarts the prescaler phase. With a divisor of D and a source tick every cycle, the first increment after a write lands D edges after the loading edge.
- R6: A wrap from 0xFF to 0x00 sets the flag and makes the pulse high for exactly one cycle. The pulse appears in the same cycle in which the count reads 0x00.
- R7: The flag stays set until the clear strobe is high at a clock edge. The clear takes priority over a wrap at that same edge.
- R8: In pin mode, a rising pin level first seen at edge k increments the counter at edge k+2 when the prescaler is bypassed. A pin held high counts once, and the instruction-cycle strobe is ignored. In strobe mode the pin is ignored.
- R9: In strobe mode, the counter advances only at edges where the instruction-cycle strobe is high.
- R10: With a tick every cycle, a 2:1 ratio and a start value of 0x06, the flag rises 500 edges after the edge that loads the count, which is 250 increments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | Instruction-cycle strobe (internal source) |
| ext_pin | input | 1 | External count pin, asynchronous |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write value |
| opt_wr | input | 1 | Control word write strobe |
| opt_wdata | input | 8 | Control word value (bit 5 source, bit 3 prescaler bypass, bits 2:0 ratio) |
| flag_clr | input | 1 | Overflow flag clear strobe |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle overflow pulse |

## Verification
Two pairs of functions can fall in the same cycle. A wrap can coincide with a flag clear, and an increment can coincide with a count write. The bench loads 0xFF with the prescaler bypassed and raises the clear strobe for exactly the edge that wraps the count. It expects the pulse to fire while the flag reads low afterwards. In a second case it writes a new value at the edge that would wrap the count. There it expects the written value, no pulse and an unchanged flag.

// File: rtl/tick_timer8_pkg.sv
package tick_timer8_pkg;

  localparam int OPT_W          = 8;
  localparam int OPT_SRC_BIT    = 5;
  localparam int OPT_BYPASS_BIT = 3;
  localparam int OPT_RATIO_LSB  = 0;
  localparam int RATIO_W        = 3;

  localparam logic [OPT_W-1:0] OPT_USED_MASK = 8'b0010_1111;

  typedef enum logic {
    SRC_CYCLE = 1'b0,
    SRC_PIN   = 1'b1
  } src_sel_e;

  typedef struct packed {
    src_sel_e             src;
    logic                 bypass;
    logic [RATIO_W-1:0]   ratio;
  } opt_t;

  localparam opt_t OPT_RESET = '{src: SRC_CYCLE, bypass: 1'b0, ratio: '0};

endpackage

// File: rtl/tick_timer8_src.sv
module tick_timer8_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_mode,
  input  logic cyc_tick,
  input  logic ext_pin,
  output logic src_tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_rise;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ext_pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign pin_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign src_tick = pin_mode ? pin_rise : cyc_tick;

endmodule

// File: rtl/tick_timer8_presc.sv
module tick_timer8_presc #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               src_tick,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  output logic               inc_tick
);

  localparam int PRE_W = 1 << RATIO_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_ones;
  logic             period_end;

  genvar i;
  generate
    for (i = 0; i < PRE_W; i++) begin : g_ones
      if (i == 0) begin : g_lsb
        assign low_ones[0] = pre_q[0];
      end else begin : g_up
        assign low_ones[i] = low_ones[i-1] & pre_q[i];
      end
    end
  endgenerate

  assign period_end = low_ones[ratio];

  always_ff @(posedge clk) begin
    if (!rst_n)                pre_q <= '0;
    else if (restart || bypass) pre_q <= '0;
    else if (src_tick)          pre_q <= pre_q + 1'b1;
  end

  assign inc_tick = src_tick & (bypass | period_end);

endmodule

// File: rtl/tick_timer8_cnt.sv
module tick_timer8_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             inc,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             flag_q,
  output logic             pulse_q
);

  logic wrap;

  assign wrap = inc & ~ld_en & (&count_q);

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (ld_en) count_q <= ld_val;
    else if (inc)   count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (flag_clr) flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
  end

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tick_timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             ext_pin,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             opt_wr,
  input  logic [OPT_W-1:0] opt_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             ovf_pulse
);

  opt_t opt_q;
  opt_t opt_next;
  logic opt_bits_unused;
  logic src_tick;
  logic inc_tick;

  assign opt_next = '{
    src:    src_sel_e'(opt_wdata[OPT_SRC_BIT]),
    bypass: opt_wdata[OPT_BYPASS_BIT],
    ratio:  opt_wdata[OPT_RATIO_LSB +: RATIO_W]
  };
  assign opt_bits_unused = ^(opt_wdata & ~OPT_USED_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n)      opt_q <= OPT_RESET;
    else if (opt_wr) opt_q <= opt_next;
  end

  tick_timer8_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_mode (opt_q.src == SRC_PIN),
    .cyc_tick (cyc_tick),
    .ext_pin  (ext_pin),
    .src_tick (src_tick)
  );

  tick_timer8_presc #(.RATIO_W(RATIO_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cnt_wr),
    .src_tick (src_tick),
    .bypass   (opt_q.bypass),
    .ratio    (opt_q.ratio),
    .inc_tick (inc_tick)
  );

  tick_timer8_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (cnt_wr),
    .ld_val   (cnt_wdata),
    .inc      (inc_tick),
    .flag_clr (flag_clr),
    .count_q  (count),
    .flag_q   (ovf_flag),
    .pulse_q  (ovf_pulse)
  );

endmodule

// File: rtl/tick_timer8_chk.sv
module tick_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             ovf_pulse
);

  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata)); // R2

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R9

  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> count == '0); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R6

  AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (ovf_flag || $past(flag_clr))); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !ovf_flag); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R7

endmodule

bind tick_timer8 tick_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .flag_clr  (flag_clr),
  .count     (count),
  .ovf_flag  (ovf_flag),
  .ovf_pulse (ovf_pulse)
);

// File: tb/tick_timer8_tb.sv
module tick_timer8_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b1;
  logic       ext_pin = 1'b0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       opt_wr = 1'b0;
  logic [7:0] opt_wdata = '0;
  logic       flag_clr = 1'b0;
  logic [7:0] count;
  logic       ovf_flag;
  logic       ovf_pulse;

  int cyc = 0;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [7:0] cnt;
    logic       flag;
    logic       pulse;
    logic [2:0] mask;
    string      req;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer8 u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_tick  (cyc_tick),
    .ext_pin   (ext_pin),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .opt_wr    (opt_wr),
    .opt_wdata (opt_wdata),
    .flag_clr  (flag_clr),
    .count     (count),
    .ovf_flag  (ovf_flag),
    .ovf_pulse (ovf_pulse)
  );

  task automatic check(string req, string what, int got, int expv);
    total++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: got %0h expected %0h", req, what, cyc, got, expv);
    end
  endtask

  task automatic expect_at(int at, logic [7:0] c, logic f, logic p, logic [2:0] m, string r);
    exp_t e;
    e.at = at; e.cnt = c; e.flag = f; e.pulse = p; e.mask = m; e.req = r;
    sb.push_back(e);
  endtask

  // monitor: pops expected items as their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      mon_e = sb.pop_front();
      if (mon_e.at < cyc) begin
        check(mon_e.req, "missed sample", cyc, mon_e.at);
      end else begin
        if (mon_e.mask[0]) check(mon_e.req, "count", int'(count), int'(mon_e.cnt));
        if (mon_e.mask[1]) check(mon_e.req, "flag", int'(ovf_flag), int'(mon_e.flag));
        if (mon_e.mask[2]) check(mon_e.req, "pulse", int'(ovf_pulse), int'(mon_e.pulse));
      end
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_cnt(logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic write_opt(logic [7:0] v);
    opt_wr = 1'b1; opt_wdata = v;
    @(negedge clk);
    opt_wr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    check("R1", "reset count", int'(count), 0);
    check("R1", "reset flag", int'(ovf_flag), 0);
    check("R1", "reset pulse", int'(ovf_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 with reset control word (2:1, in path), start value 0x06
    t = cyc;
    expect_at(t + 1,   8'h06, 1'b0, 1'b0, 3'b111, "R2");
    expect_at(t + 3,   8'h07, 1'b0, 1'b0, 3'b111, "R4");
    expect_at(t + 499, 8'hFF, 1'b0, 1'b0, 3'b111, "R10");
    expect_at(t + 501, 8'h00, 1'b1, 1'b1, 3'b111, "R10");
    expect_at(t + 502, 8'h00, 1'b1, 1'b0, 3'b111, "R6");
    write_cnt(8'h06);
    drain();

    // R7 sticky flag
    t = cyc;
    expect_at(t + 30, 8'h00, 1'b1, 1'b0, 3'b010, "R7");
    drain();

    // R7 clear and wrap at the same edge, prescaler bypassed (R3)
    write_opt(8'h08);
    t = cyc;
    expect_at(t + 2, 8'h00, 1'b0, 1'b1, 3'b111, "R7");
    expect_at(t + 3, 8'h01, 1'b0, 1'b0, 3'b111, "R3");
    cnt_wr = 1'b1; cnt_wdata = 8'hFF;
    @(negedge clk);
    cnt_wr = 1'b0; flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    drain();

    // R2 write at the edge that would wrap
    t = cyc;
    expect_at(t + 2, 8'h80, 1'b0, 1'b0, 3'b111, "R2");
    expect_at(t + 3, 8'h81, 1'b0, 1'b0, 3'b111, "R2");
    cnt_wr = 1'b1; cnt_wdata = 8'hFF;
    @(negedge clk);
    cnt_wdata = 8'h80;
    @(negedge clk);
    cnt_wr = 1'b0;
    drain();

    // R9 strobe gating, R8 pin ignored in strobe mode
    cyc_tick = 1'b0;
    t = cyc;
    expect_at(t + 1,  8'h10, 1'b0, 1'b0, 3'b111, "R9");
    expect_at(t + 15, 8'h10, 1'b0, 1'b0, 3'b001, "R8");
    expect_at(t + 18, 8'h13, 1'b0, 1'b0, 3'b001, "R9");
    expect_at(t + 25, 8'h13, 1'b0, 1'b0, 3'b001, "R9");
    write_cnt(8'h10);
    wait_until(t + 5);  ext_pin = 1'b1;
    wait_until(t + 10); ext_pin = 1'b0;
    wait_until(t + 15); cyc_tick = 1'b1;
    repeat (3) @(negedge clk);
    cyc_tick = 1'b0;
    drain();
    cyc_tick = 1'b1;

    // R4 ratio 256:1, R3 ignored bits 7,6,4 set
    write_opt(8'hD7);
    t = cyc;
    expect_at(t + 256, 8'hFE, 1'b0, 1'b0, 3'b001, "R4");
    expect_at(t + 257, 8'hFF, 1'b0, 1'b0, 3'b001, "R4");
    expect_at(t + 512, 8'hFF, 1'b0, 1'b0, 3'b111, "R3");
    expect_at(t + 513, 8'h00, 1'b1, 1'b1, 3'b111, "R6");
    write_cnt(8'hFE);
    drain();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;

    // R5 prescaler restart on count write, ratio 8:1
    write_opt(8'h02);
    t = cyc;
    expect_at(t + 1,  8'h10, 1'b0, 1'b0, 3'b111, "R5");
    expect_at(t + 5,  8'h10, 1'b0, 1'b0, 3'b001, "R5");
    expect_at(t + 6,  8'h20, 1'b0, 1'b0, 3'b001, "R5");
    expect_at(t + 13, 8'h20, 1'b0, 1'b0, 3'b001, "R5");
    expect_at(t + 14, 8'h21, 1'b0, 1'b0, 3'b001, "R5");
    write_cnt(8'h10);
    wait_until(t + 5);
    write_cnt(8'h20);
    drain();

    // R8 pin mode with bypass, strobe held high and ignored (R3 bit 5)
    write_opt(8'h28);
    t = cyc;
    expect_at(t + 1,  8'h40, 1'b0, 1'b0, 3'b001, "R3");
    expect_at(t + 10, 8'h40, 1'b0, 1'b0, 3'b001, "R8");
    expect_at(t + 12, 8'h40, 1'b0, 1'b0, 3'b001, "R8");
    expect_at(t + 13, 8'h41, 1'b0, 1'b0, 3'b001, "R8");
    expect_at(t + 20, 8'h41, 1'b0, 1'b0, 3'b001, "R8");
    expect_at(t + 26, 8'h41, 1'b0, 1'b0, 3'b001, "R8");
    expect_at(t + 27, 8'h42, 1'b0, 1'b0, 3'b001, "R8");
    write_cnt(8'h40);
    wait_until(t + 10); ext_pin = 1'b1;
    wait_until(t + 20); ext_pin = 1'b0;
    wait_until(t + 24); ext_pin = 1'b1;
    drain();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule